// File: doc/BRIEF.md
# Pointer Register Address Generator

This block turns a request that names one of three 16-bit pointer registers and an addressing mode into a data-memory operand address. The pointers are called X, Y and Z. Three modes are supported: plain indirect, indirect with post-increment, and indirect with pre-decrement. In plain indirect mode the address is the pointer as it stands. In post-increment mode the address is the value before the access, and the pointer steps up by one afterwards. In pre-decrement mode the pointer steps down by one first, and that lowered value is the address. The chosen pointer is updated in place at the clock edge that ends an accepted access.

The request side is a valid/ready stream. The address leaves the block combinationally, in the same cycle, and is qualified by `addr_valid`. A downstream consumer may apply back-pressure with `addr_ready`. That signal passes straight through to `req_ready`, and an access counts as taken, so that its pointer update happens, only in a cycle where `req_valid` and `addr_ready` are both high. During a stall the requester must hold its request fields stable. The address then stays the same, because no pointer moves until the transfer completes.

A separate load port writes any pointer directly. This is used to set pointers up before a run of accesses. All three pointers are read back continuously on a flat bus.

Top module: `ptr_agen`

## Requirements
- R1: A synchronous active-high `rst` clears X, Y and Z to 0x0000, and the read-back shows zeros in the cycle after the reset edge.
- R2: Mode code 2'b00 (plain) drives `addr` with the selected pointer and leaves every pointer unchanged.
- R3: Mode code 2'b01 (post-increment) drives `addr` with the selected pointer's current value, and after the accepting edge that pointer holds its old value plus one.
- R4: Mode code 2'b10 (pre-decrement) drives `addr` with the selected pointer minus one in the same cycle, and after the accepting edge that pointer holds that reduced value.
- R5: Mode code 2'b11 is reserved and behaves as plain: `addr` equals the pointer and nothing is updated.
- R6: Stepping wraps modulo 2^16: 0x0000 minus one gives 0xFFFF, and 0xFFFF plus one gives 0x0000.
- R7: `addr_valid` equals `req_valid`, and `req_ready` equals `addr_ready`. When `req_valid` is high and `addr_ready` is low, no pointer changes.
- R8: When `req_valid` is low, `addr_valid` is low and no pointer is modified by the request inputs.
- R9: When `ld_en` is high, `ld_data` is written into the pointer chosen by `ld_sel` at the edge. If an accepted access updates the same pointer in that cycle, the load wins. A load to a different pointer and an access update both take effect.
- R10: Pointer select codes are 0 = X, 1 = Y, 2 = Z. Select code 3 gives `addr` = 0x0000 and updates nothing, and a load with `ld_sel` = 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_ready | output | 1 | Request accepted this cycle (follows addr_ready) |
| req_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| req_mode | input | 2 | Addressing mode: 00 plain, 01 post-increment, 10 pre-decrement, 11 reserved |
| addr_valid | output | 1 | Operand address qualifier |
| addr_ready | input | 1 | Downstream can take the address |
| addr | output | 16 | Operand address |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load |
| ld_data | input | 16 | Value to load |
| ptr_rd | output | 48 | Read-back: X in [15:0], Y in [31:16], Z in [47:32] |

## Verification
The assertions take for granted that every input is two-valued from the first reset edge onward and changes only between clock edges. The properties that check a held pointer also assume that no load hits that pointer in the same cycle. For that reason their antecedents require `ld_en` to be low, or the targeted pointer to differ from the loaded one. The bench drives all inputs on the falling edge. It sweeps every combination of valid, ready, select (including the unused code 3) and mode over seed values that sit at both wrap points. It adds loads that collide with accesses only in cycles set aside for the load-priority checks.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'b00,
    AM_POSTINC = 2'b01,
    AM_PREDEC  = 2'b10,
    AM_RSVD    = 2'b11
  } amode_e;

endpackage

// File: rtl/ptr_agen_step.sv
module ptr_agen_step
  import ptr_agen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  amode_e       mode,
  output logic [W-1:0] eff_addr,
  output logic [W-1:0] nxt,
  output logic         upd
);

  logic [W-1:0] inc_val;
  logic [W-1:0] dec_val;

  // Arithmetic wraps naturally modulo 2^W.
  assign inc_val = cur + W'(1);
  assign dec_val = cur - W'(1);

  always_comb begin
    eff_addr = cur;
    nxt      = cur;
    upd      = 1'b0;
    unique case (mode)
      AM_POSTINC: begin
        eff_addr = cur;
        nxt      = inc_val;
        upd      = 1'b1;
      end
      AM_PREDEC: begin
        eff_addr = dec_val;
        nxt      = dec_val;
        upd      = 1'b1;
      end
      default: begin
        eff_addr = cur;
        nxt      = cur;
        upd      = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ptr_agen_mux.sv
module ptr_agen_mux #(
  parameter int W     = 16,
  parameter int N     = 3,
  parameter int SEL_W = 2
) (
  input  logic [N*W-1:0] flat,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]   q,
  output logic           hit
);

  always_comb begin
    q   = '0;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) begin
        q   = flat[i*W +: W];
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ptr_agen_bank.sv
module ptr_agen_bank #(
  parameter int W     = 16,
  parameter int N     = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [W-1:0]     ld_data,
  output logic [N*W-1:0]   flat
);

  for (genvar g = 0; g < N; g++) begin : g_ptr
    logic [W-1:0] r;
    logic ld_hit;
    logic wr_hit;

    assign ld_hit = ld_en && (ld_sel == SEL_W'(g));
    assign wr_hit = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst)         r <= '0;
      else if (ld_hit) r <= ld_data;
      else if (wr_hit) r <= wr_data;
    end

    assign flat[g*W +: W] = r;
  end

endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
  import ptr_agen_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int NUM_PTR = 3,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR + 1) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [SEL_W-1:0]         req_sel,
  input  logic [1:0]               req_mode,
  output logic                     addr_valid,
  input  logic                     addr_ready,
  output logic [PTR_W-1:0]         addr,
  input  logic                     ld_en,
  input  logic [SEL_W-1:0]         ld_sel,
  input  logic [PTR_W-1:0]         ld_data,
  output logic [NUM_PTR*PTR_W-1:0] ptr_rd
);

  logic [PTR_W-1:0] cur_ptr;
  logic             sel_hit;
  logic [PTR_W-1:0] step_addr;
  logic [PTR_W-1:0] step_nxt;
  logic             step_upd;
  logic             take;
  amode_e           mode_e;

  assign mode_e = amode_e'(req_mode);

  ptr_agen_mux #(.W(PTR_W), .N(NUM_PTR), .SEL_W(SEL_W)) u_mux (
    .flat (ptr_rd),
    .sel  (req_sel),
    .q    (cur_ptr),
    .hit  (sel_hit)
  );

  ptr_agen_step #(.W(PTR_W)) u_step (
    .cur      (cur_ptr),
    .mode     (mode_e),
    .eff_addr (step_addr),
    .nxt      (step_nxt),
    .upd      (step_upd)
  );

  assign req_ready  = addr_ready;
  assign addr_valid = req_valid;
  assign addr       = sel_hit ? step_addr : '0;
  assign take       = req_valid && addr_ready && sel_hit && step_upd;

  ptr_agen_bank #(.W(PTR_W), .N(NUM_PTR), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take),
    .wr_sel  (req_sel),
    .wr_data (step_nxt),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .flat    (ptr_rd)
  );

endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
  parameter int W     = 16,
  parameter int N     = 3,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEL_W-1:0] req_sel,
  input logic [1:0]       req_mode,
  input logic             addr_valid,
  input logic             addr_ready,
  input logic [W-1:0]     addr,
  input logic             ld_en,
  input logic [SEL_W-1:0] ld_sel,
  input logic [W-1:0]     ld_data,
  input logic [N*W-1:0]   ptr_rd
);

  logic             q_fire;
  logic [SEL_W-1:0] q_sel;
  logic [1:0]       q_mode;
  logic [W-1:0]     q_addr;
  logic             q_ld_hit;
  logic             q_ld;
  logic [SEL_W-1:0] q_ld_sel;
  logic [W-1:0]     q_ld_data;
  logic [W-1:0]     q_now;
  logic [W-1:0]     q_ld_now;
  logic [W-1:0]     cur_now;
  logic             sel_ok;

  assign sel_ok = int'(req_sel) < N;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_fire    <= 1'b0;
      q_sel     <= '0;
      q_mode    <= '0;
      q_addr    <= '0;
      q_ld_hit  <= 1'b0;
      q_ld      <= 1'b0;
      q_ld_sel  <= '0;
      q_ld_data <= '0;
    end else begin
      q_fire    <= req_valid && addr_ready && sel_ok;
      q_sel     <= req_sel;
      q_mode    <= req_mode;
      q_addr    <= addr;
      q_ld_hit  <= ld_en && (ld_sel == req_sel);
      q_ld      <= ld_en && (int'(ld_sel) < N);
      q_ld_sel  <= ld_sel;
      q_ld_data <= ld_data;
    end
  end

  always_comb begin
    q_now    = '0;
    q_ld_now = '0;
    cur_now  = '0;
    for (int i = 0; i < N; i++) begin
      if (q_sel == SEL_W'(i))    q_now    = ptr_rd[i*W +: W];
      if (q_ld_sel == SEL_W'(i)) q_ld_now = ptr_rd[i*W +: W];
      if (req_sel == SEL_W'(i))  cur_now  = ptr_rd[i*W +: W];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (ptr_rd == '0));

  // R2
  plain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b00 && !ld_en) |=> $stable(ptr_rd));

  // R3
  postinc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (q_fire && q_mode == 2'b01 && !q_ld_hit) |-> (q_now == W'(q_addr + W'(1))));

  // R4
  predec_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel_ok && req_mode == 2'b10) |-> (addr == W'(cur_now - W'(1))));

  // R4
  predec_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (q_fire && q_mode == 2'b10 && !q_ld_hit) |-> (q_now == q_addr));

  // R5
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b11 && !ld_en) |=> $stable(ptr_rd));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !addr_ready && !ld_en) |=> $stable(ptr_rd));

  // R8
  idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !addr_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !ld_en) |=> $stable(ptr_rd));

  // R9
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    q_ld |-> (q_ld_now == q_ld_data));

  // R10
  badsel_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !sel_ok) |-> (addr == '0));

endmodule

bind ptr_agen ptr_agen_chk #(.W(PTR_W), .N(NUM_PTR), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_sel    (req_sel),
  .req_mode   (req_mode),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr       (addr),
  .ld_en      (ld_en),
  .ld_sel     (ld_sel),
  .ld_data    (ld_data),
  .ptr_rd     (ptr_rd)
);

// File: tb/test_ptr_agen.sv
`timescale 1ns/1ps
module test_ptr_agen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic [1:0]  req_mode = '0;
  logic        addr_valid;
  logic        addr_ready = 1'b0;
  logic [15:0] addr;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic [47:0] ptr_rd;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] mdl [3];

  always #2 clk = ~clk;

  ptr_agen i_ptr_agen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_mode(req_mode), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr(addr), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .ptr_rd(ptr_rd)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string auto_tag(bit v, bit rdy, logic [1:0] s, logic [1:0] m);
    if (!v) return "R8";
    if (s == 2'd3) return "R10";
    if (!rdy) return "R7";
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_ptrs(input string tag);
    for (int i = 0; i < 3; i++)
      chk(ptr_rd[i*16 +: 16] === mdl[i], tag, $sformatf("ptr%0d", i),
          48'(ptr_rd[i*16 +: 16]), 48'(mdl[i]));
  endtask

  task automatic step(input bit v, input logic [1:0] s, input logic [1:0] m,
                      input bit rdy, input bit ld, input logic [1:0] lsel,
                      input logic [15:0] ldat, input string tag_in);
    string tag;
    logic [15:0] ea;
    logic [15:0] nv;
    tag = (tag_in == "") ? auto_tag(v, rdy, s, m) : tag_in;
    @(negedge clk);
    req_valid = v; req_sel = s; req_mode = m; addr_ready = rdy;
    ld_en = ld; ld_sel = lsel; ld_data = ldat;
    #0.5;
    ea = 16'h0000;
    if (s != 2'd3) ea = (m == 2'b10) ? mdl[s] - 16'd1 : mdl[s];
    chk(addr_valid === v, "R7", "addr_valid", 48'(addr_valid), 48'(v));
    chk(req_ready === rdy, "R7", "req_ready", 48'(req_ready), 48'(rdy));
    if (v) chk(addr === ea, tag, "addr", 48'(addr), 48'(ea));
    @(posedge clk);
    if (v && rdy && s != 2'd3) begin
      nv = mdl[s];
      if (m == 2'b01) nv = mdl[s] + 16'd1;
      if (m == 2'b10) nv = mdl[s] - 16'd1;
      mdl[s] = nv;
    end
    if (ld && lsel != 2'd3) mdl[lsel] = ldat;
    #0.5;
    check_ptrs(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; ld_en = 1'b0;
    @(posedge clk);
    #0.5;
    for (int i = 0; i < 3; i++) mdl[i] = 16'h0000;
    check_ptrs("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [15:0] seeds [4];
    seeds[0] = 16'h0000; seeds[1] = 16'h0001;
    seeds[2] = 16'h8000; seeds[3] = 16'hFFFF;
    for (int i = 0; i < 3; i++) mdl[i] = 16'h0000;
    do_reset();

    // Sweep every valid/ready/select/mode combination over wrap-edge seeds.
    for (int sd = 0; sd < 4; sd++)
      for (int v = 0; v < 2; v++)
        for (int r = 0; r < 2; r++)
          for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++) begin
              step(1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 2'(s), seeds[sd] ^ 16'(s*16'h0101), "R9");
              step(1'(v), 2'(s), 2'(m), 1'(r), 1'b0, 2'd0, 16'h0, "");
            end

    // R6: pre-decrement across zero, then post-increments across the top.
    step(1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 16'h0001, "R9");
    for (int k = 0; k < 3; k++) step(1'b1, 2'd0, 2'b10, 1'b1, 1'b0, 2'd0, 16'h0, "R6");
    step(1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 2'd1, 16'hFFFD, "R9");
    for (int k = 0; k < 5; k++) step(1'b1, 2'd1, 2'b01, 1'b1, 1'b0, 2'd0, 16'h0, "R6");

    // Back-to-back mixed modes and pointers.
    for (int k = 0; k < 24; k++)
      step(1'b1, 2'(k % 3), 2'((k * 7) % 4), 1'(k % 5 != 4), 1'b0, 2'd0, 16'h0, "");

    // R9: load collides with an access on the same pointer; load wins.
    step(1'b1, 2'd2, 2'b01, 1'b1, 1'b1, 2'd2, 16'h1234, "R9");
    step(1'b1, 2'd2, 2'b10, 1'b1, 1'b1, 2'd2, 16'hABCD, "R9");
    // R9: load and access on different pointers both land.
    step(1'b1, 2'd0, 2'b01, 1'b1, 1'b1, 2'd1, 16'h5A5A, "R9");
    // R10: load to select 3 is ignored.
    step(1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 2'd3, 16'hDEAD, "R10");

    do_reset();
    step(1'b1, 2'd1, 2'b10, 1'b1, 1'b0, 2'd0, 16'h0, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule